// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block is a management-bus master that runs exactly one Clause 22 transaction with an external PHY for each command that software issues. Software fills a small register set. It loads the value to be written into a data register. It then writes a command word that holds a launch flag, a transfer direction, a 5-bit PHY address and a 5-bit register address. The controller derives the management clock from the system clock and shifts out the complete serial frame. For a read it releases the data line and collects the PHY's answer. When the frame ends it drops the launch flag.

Software polls the launch flag of the command register until it reads back as zero. It then takes read results from the upper half of the data register. A one-bit status register reports whether the last read received a response. A read gets no response when no device pulled the line low in the second turnaround slot.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: Command register bit 20 reads 1 from the cycle after an accepted launch until the frame ends, and reads 0 afterwards without any software action.
- R2: A command write with bit 20 set starts a read when bit 17 is set, and bit 17 wins if bit 16 is also set. It starts a write when only bit 16 is set. A command write with bit 20 clear, or with neither bit 17 nor bit 16 set, starts nothing.
- R3: The command word carries the PHY address in bits 12:8 and the register address in bits 4:0. The frame is sent MSB first as 32 ones, start 01, opcode (10 read, 01 write), PHY address, register address, two turnaround bits, then 16 data bits.
- R4: A write frame sends bits 15:0 of the data register as its data field and drives turnaround as 1 then 0. The output enable stays high for all 64 bits.
- R5: A read frame keeps the output enable low for the two turnaround bits and the 16 data bits. It samples the line on rising MDC edges and places the 16 received bits in data register bits 31:16.
- R6: Status register bit 0 is set at the end of a read whose second turnaround bit was sampled high, and cleared at the end of a read where it was sampled low. A write frame leaves it unchanged.
- R7: MDC stays low while idle and has a period of 2*MDC_HALF system clocks during a frame. The data line changes only when MDC falls.
- R8: A command write that arrives while bit 20 reads 1 is ignored. The stored fields stay as they were and no further frame follows.
- R9: A software write to the data register (select 1) updates only bits 15:0. Bits 31:16 change only at the end of a read. The command register is select 0 and the status register is select 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 command, 1 data, 2 status |
| csr_wdata | input | 32 | Register write value |
| csr_rdata | output | 32 | Read value of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | High while the master drives the data line |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
The embedded assertions check four things on every cycle. The launch flag must rise after an accepted launch and fall after the final bit. The data line must hold steady while MDC is high. The divider strobes must never coincide, and MDC must be low when idle. The stored command fields and the upper data half must not move while a command is ignored or no read is finishing. Only the bench scenarios, where a PHY model captures frames on rising MDC edges and answers reads, can show the rest. That covers the exact bit layout of each frame, the release window of the output enable, the received word and the no-response flag for present and absent PHYs, and the decode of incomplete command words.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int CSR_W      = 32;
   localparam int START_BIT  = 20;
   localparam int RD_BIT     = 17;
   localparam int WR_BIT     = 16;
   localparam int PHY_LSB    = 8;
   localparam int REG_LSB    = 0;
   localparam int ADR_W      = 5;
   localparam int DATA_W     = 16;
   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADR_W + 2 + DATA_W;
   localparam int TA_POS     = FRAME_BITS - DATA_W - 2;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2
   } sel_e;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } op_e;

   typedef struct packed {
      op_e              op;
      logic [ADR_W-1:0] phy;
      logic [ADR_W-1:0] regad;
   } req_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic mdc_q;
   logic tick;

   initial assert (HALF >= 1) else $error("mdio_mdc_div: HALF must be at least 1");

   generate
      if (HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mdc_q <= 1'b0;
            else if (!run)   mdc_q <= 1'b0;
            else             mdc_q <= ~mdc_q;
         end
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               mdc_q <= 1'b0;
            end else if (!run) begin
               cnt_q <= '0;
               mdc_q <= 1'b0;
            end else if (cnt_q == CW'(HALF - 1)) begin
               cnt_q <= '0;
               mdc_q <= ~mdc_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   assign mdc  = mdc_q;
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;

   assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  req_t              req,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_word,
   output logic              rd_fail
);
   localparam int CNT_W  = $clog2(FRAME_BITS);
   localparam int LAST   = FRAME_BITS - 1;
   localparam int TA2    = TA_POS + 1;
   localparam int DSTART = TA_POS + 2;

   logic                  active_q;
   op_e                   op_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [FRAME_BITS-1:0] shreg_q;
   logic [DATA_W-1:0]     rx_q;
   logic                  fail_q;
   logic [FRAME_BITS-1:0] frame_w;
   logic                  is_rd;
   logic                  last_w;

   always_comb begin
      is_rd   = (req.op == OP_READ);
      frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                 is_rd ? 2'b10 : 2'b01,
                 req.phy, req.regad,
                 is_rd ? 2'b11 : 2'b10,
                 is_rd ? {DATA_W{1'b1}} : wdata};
   end

   assign last_w = active_q && fall && (cnt_q == CNT_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         op_q     <= OP_WRITE;
         cnt_q    <= '0;
         shreg_q  <= '0;
         rx_q     <= '0;
         fail_q   <= 1'b0;
      end else if (launch && !active_q) begin
         active_q <= 1'b1;
         op_q     <= req.op;
         cnt_q    <= '0;
         shreg_q  <= frame_w;
         rx_q     <= '0;
         fail_q   <= 1'b0;
      end else if (active_q) begin
         if (rise && op_q == OP_READ) begin
            if (cnt_q == CNT_W'(TA2))
               fail_q <= mdio_i;
            else if (cnt_q >= CNT_W'(DSTART))
               rx_q <= {rx_q[DATA_W-2:0], mdio_i};
         end
         if (fall) begin
            if (last_w) begin
               active_q <= 1'b0;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
               shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
            end
         end
      end
   end

   assign busy    = active_q;
   assign mdio_o  = shreg_q[FRAME_BITS-1];
   assign mdio_oe = active_q && (op_q == OP_WRITE || cnt_q < CNT_W'(TA_POS));
   assign done    = last_w;
   assign rd_done = last_w && (op_q == OP_READ);
   assign rd_word = rx_q;
   assign rd_fail = fail_q;

   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
   assert_done_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
   import mdio_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [1:0]        csr_sel,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [CSR_W-1:0]  csr_rdata,
   input  logic              busy,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              rd_fail,
   output logic              launch,
   output req_t              req,
   output logic [DATA_W-1:0] wdata_lo
);
   logic              rdsel_q, wrsel_q, bad_q;
   logic [ADR_W-1:0]  phy_q, reg_q;
   logic [DATA_W-1:0] lo_q, hi_q;
   logic              cmd_we, data_we, accept;
   logic [CSR_W-1:0]  cmd_rb;
   logic              unused_bits;

   assign cmd_we  = csr_we && (csr_sel == SEL_CMD);
   assign data_we = csr_we && (csr_sel == SEL_DATA);
   assign accept  = cmd_we && !busy;
   assign launch  = accept && csr_wdata[START_BIT] &&
                    (csr_wdata[RD_BIT] || csr_wdata[WR_BIT]);

   always_comb begin
      req.op    = csr_wdata[RD_BIT] ? OP_READ : OP_WRITE;
      req.phy   = csr_wdata[PHY_LSB +: ADR_W];
      req.regad = csr_wdata[REG_LSB +: ADR_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdsel_q <= 1'b0;
         wrsel_q <= 1'b0;
         phy_q   <= '0;
         reg_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         bad_q   <= 1'b0;
      end else begin
         if (accept) begin
            rdsel_q <= csr_wdata[RD_BIT];
            wrsel_q <= csr_wdata[WR_BIT];
            phy_q   <= csr_wdata[PHY_LSB +: ADR_W];
            reg_q   <= csr_wdata[REG_LSB +: ADR_W];
         end
         if (data_we) lo_q <= csr_wdata[DATA_W-1:0];
         if (rd_done) begin
            hi_q  <= rd_word;
            bad_q <= rd_fail;
         end
      end
   end

   always_comb begin
      cmd_rb                        = '0;
      cmd_rb[START_BIT]             = busy;
      cmd_rb[RD_BIT]                = rdsel_q;
      cmd_rb[WR_BIT]                = wrsel_q;
      cmd_rb[PHY_LSB +: ADR_W]      = phy_q;
      cmd_rb[REG_LSB +: ADR_W]      = reg_q;
      if (csr_sel == SEL_CMD)       csr_rdata = cmd_rb;
      else if (csr_sel == SEL_DATA) csr_rdata = {hi_q, lo_q};
      else if (csr_sel == SEL_STAT) csr_rdata = {{(CSR_W-1){1'b0}}, bad_q};
      else                          csr_rdata = '0;
   end

   assign wdata_lo    = lo_q;
   assign unused_bits = ^{csr_wdata[CSR_W-1:START_BIT+1], csr_wdata[START_BIT-1:RD_BIT+1]};

   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> ($stable(phy_q) && $stable(reg_q) && $stable(rdsel_q)));
   assert_hi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |=> $stable(hi_q));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_cmd_pkg::*;
#(
   parameter int MDC_HALF = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [1:0]  csr_sel,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic              busy, launch, rise, fall, done, rd_done, rd_fail;
   req_t              req;
   logic [DATA_W-1:0] wdata_lo, rd_word;

   mdio_csr u_csr (
      .clk, .rst_n, .csr_we, .csr_sel, .csr_wdata, .csr_rdata,
      .busy, .rd_done, .rd_word, .rd_fail,
      .launch, .req, .wdata_lo
   );

   mdio_mdc_div #(.HALF(MDC_HALF)) u_div (
      .clk, .rst_n, .run(busy), .mdc, .rise, .fall
   );

   mdio_frame_eng u_eng (
      .clk, .rst_n, .launch, .req, .wdata(wdata_lo), .rise, .fall, .mdio_i,
      .busy, .mdio_o, .mdio_oe, .done, .rd_done, .rd_word, .rd_fail
   );

   assert_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);
   assert_mdio_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> $stable(mdio_o));
endmodule

// File: tb/mdio_cmd_ctrl_test.sv
module mdio_cmd_ctrl_test;
   localparam int HALF = 2;
   localparam int NV   = 6;
   // fields: rd, present, phy[5], reg[5], wdata[16], resp[16]
   localparam logic [43:0] VEC [0:NV-1] = '{
      {1'b0, 1'b1, 5'd1,  5'd0,  16'h1234, 16'h0000},
      {1'b1, 1'b1, 5'd1,  5'd2,  16'h0000, 16'h796D},
      {1'b1, 1'b0, 5'd31, 5'd31, 16'h0000, 16'h0000},
      {1'b0, 1'b1, 5'd21, 5'd10, 16'hA5C3, 16'h0000},
      {1'b1, 1'b1, 5'd0,  5'd3,  16'h0000, 16'h8001},
      {1'b0, 1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0000}
   };

   logic clk = 1'b0, rst_n = 1'b0, csr_we = 1'b0;
   logic [1:0] csr_sel = 2'd0;
   logic [31:0] csr_wdata = '0, csr_rdata;
   logic mdc, mdio_o, mdio_oe, mdio_i;

   int errors = 0, checks = 0, rises = 0, cycles = 0;
   logic [63:0] cap, oecap;
   time t_prev, t_last;
   logic m_present = 1'b1;
   logic [15:0] m_resp = '0;
   logic [15:0] exp_hi = '0;
   logic exp_stat = 1'b0;
   logic [31:0] rv;

   mdio_cmd_ctrl #(.MDC_HALF(HALF)) uut (
      .clk, .rst_n, .csr_we, .csr_sel, .csr_wdata, .csr_rdata,
      .mdc, .mdio_o, .mdio_oe, .mdio_i
   );

   always #5 clk = ~clk;

   initial mdio_i = 1'b1;

   // PHY model: capture on rising MDC, drive the next bit on falling MDC
   always @(posedge mdc) begin
      cap    = {cap[62:0], mdio_o};
      oecap  = {oecap[62:0], mdio_oe};
      rises  = rises + 1;
      t_prev = t_last;
      t_last = $time;
   end
   always @(negedge mdc) begin
      if (rises == 47)      mdio_i = m_present ? 1'b0 : 1'b1;
      else if (rises >= 48) mdio_i = m_present ? m_resp[63-rises] : 1'b1;
      else                  mdio_i = 1'b1;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
         summary();
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      csr_sel = sel;
      #1 d = csr_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         rd(2'd0, v);
         if (!v[20]) break;
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, r ? 2'b11 : 2'b10, r ? 16'hFFFF : d};
   endfunction

   function automatic logic [31:0] cmd_word(input logic s, input logic b17, input logic b16, input logic [4:0] p, input logic [4:0] g);
      return (32'(s) << 20) | (32'(b17) << 17) | (32'(b16) << 16) | (32'(p) << 8) | 32'(g);
   endfunction

   task automatic run_op(input bit r, input bit pres, input logic [4:0] p, input logic [4:0] g,
                         input logic [15:0] wd, input logic [15:0] resp, input string tag);
      logic [31:0] v;
      logic [63:0] ef;
      m_present = pres; m_resp = resp;
      if (!r) wr(2'd1, {16'h0, wd});
      rises = 0; cap = '0; oecap = '0;
      wr(2'd0, cmd_word(1'b1, r, !r, p, g));
      rd(2'd0, v);
      check(v[20] == 1'b1, {tag, " R1 busy after launch"}, 64'(v[20]), 64'd1);
      wait_idle();
      rd(2'd0, v);
      check(v[20] == 1'b0, {tag, " R1 busy self-clears"}, 64'(v[20]), 64'd0);
      ef = exp_frame(r, p, g, wd);
      if (r) begin
         check(cap[63:18] == ef[63:18], {tag, " R3 read header"}, cap, ef);
         check(oecap == {{46{1'b1}}, {18{1'b0}}}, {tag, " R5 release window"}, oecap, {{46{1'b1}}, {18{1'b0}}});
         exp_hi   = pres ? resp : 16'hFFFF;
         exp_stat = !pres;
      end else begin
         check(cap == ef, {tag, " R3 R4 write frame"}, cap, ef);
         check(oecap == '1, {tag, " R4 driven throughout"}, oecap, '1);
      end
      rd(2'd1, v);
      if (!r) exp_hi = exp_hi;
      check(v == {exp_hi, r ? v[15:0] : wd}, {tag, " R5 R9 data register"}, 64'(v), 64'({exp_hi, r ? v[15:0] : wd}));
      rd(2'd2, v);
      check(v == 32'(exp_stat), {tag, " R6 status"}, 64'(v), 64'(exp_stat));
      check(rises == 64, {tag, " R3 frame length"}, 64'(rises), 64'd64);
   endtask

   initial begin
      logic [31:0] v;
      cap = '0; oecap = '0; t_prev = 0; t_last = 0;
      repeat (5) @(negedge clk);
      rd(2'd0, v); check(v == 0, "R1 reset command", 64'(v), 0);
      rd(2'd1, v); check(v == 0, "R9 reset data", 64'(v), 0);
      rd(2'd2, v); check(v == 0, "R6 reset status", 64'(v), 0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 reset pins", {62'h0, mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(mdc == 1'b0, "R7 idle clock low", 64'(mdc), 0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         run_op(VEC[k][43], VEC[k][42], VEC[k][41:37], VEC[k][36:32], VEC[k][31:16], VEC[k][15:0],
                $sformatf("vec%0d", k));
         if (k == 0)
            check(t_last - t_prev == time'(2 * HALF * 10), "R7 MDC period", 64'(t_last - t_prev), 64'(2 * HALF * 10));
      end
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 idle after frames", {62'h0, mdc, mdio_oe}, 0);

      // R8: command while busy is ignored
      m_present = 1'b1; m_resp = 16'h0F0F;
      rises = 0; cap = '0;
      wr(2'd0, cmd_word(1'b1, 1'b1, 1'b0, 5'd3, 5'd4));
      wr(2'd0, cmd_word(1'b1, 1'b0, 1'b1, 5'd9, 5'd9));
      rd(2'd0, v);
      check(v[12:8] == 5'd3 && v[4:0] == 5'd4 && v[17] && !v[16], "R8 fields kept while busy",
            64'(v), 64'(cmd_word(1'b1, 1'b1, 1'b0, 5'd3, 5'd4)));
      wait_idle();
      check(cap[63:18] == exp_frame(1'b1, 5'd3, 5'd4, 16'h0)[63:18], "R8 original frame sent", cap,
            exp_frame(1'b1, 5'd3, 5'd4, 16'h0));
      repeat (300) @(negedge clk);
      check(rises == 64, "R8 no second frame", 64'(rises), 64'd64);
      rd(2'd1, v);
      check(v[31:16] == 16'h0F0F, "R8 read result kept", 64'(v[31:16]), 64'h0F0F);
      exp_hi = 16'h0F0F; exp_stat = 1'b0;

      // R2: incomplete command words start nothing
      rises = 0;
      wr(2'd0, cmd_word(1'b1, 1'b0, 1'b0, 5'd2, 5'd2));
      rd(2'd0, v);
      check(v[20] == 1'b0, "R2 start without op ignored", 64'(v[20]), 0);
      wr(2'd0, cmd_word(1'b0, 1'b1, 1'b0, 5'd2, 5'd2));
      rd(2'd0, v);
      check(v[20] == 1'b0, "R2 op without start ignored", 64'(v[20]), 0);
      repeat (100) @(negedge clk);
      check(rises == 0, "R2 no frame from incomplete words", 64'(rises), 0);

      // R2: both op bits set selects read
      m_present = 1'b1; m_resp = 16'hC33C;
      rises = 0; cap = '0;
      wr(2'd0, cmd_word(1'b1, 1'b1, 1'b1, 5'd7, 5'd1));
      wait_idle();
      check(cap[63:18] == exp_frame(1'b1, 5'd7, 5'd1, 16'h0)[63:18], "R2 both bits read opcode", cap,
            exp_frame(1'b1, 5'd7, 5'd1, 16'h0));
      exp_hi = 16'hC33C;

      // R9: software write touches low half only
      wr(2'd1, 32'hDEAD_BEEF);
      rd(2'd1, v);
      check(v == {exp_hi, 16'hBEEF}, "R9 low half only", 64'(v), 64'({exp_hi, 16'hBEEF}));

      summary();
   end
endmodule